// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 interrupt inputs and drives one active-low request line to a processor. Each input has a control word that sets how it triggers (low level, high level, falling edge or rising edge) and a 3-bit priority. Software changes the enable mask through write-one command registers. It can also raise or drop a source's pending state by command.

The processor reads a vector register to find the winning source. The value it returns is the source number times four. The same read acknowledges the source and pushes it onto an in-service stack. While a source is in service, only a source of strictly higher priority pulls the request line low again. Any write to the end-of-service register pops the stack and returns to the interrupted level.

Register access goes through a single-cycle read/write port with byte addresses. Read data is combinational from the state. The side effects of a read or write take place at the clock edge that ends the access.

Top module: `vpic_top`

## Requirements
- R1: After reset every source is disabled, every control word reads 0, nothing is in service, and `irq_n` is high.
- R2: The control word of source i sits at byte address 4*i. Bits 7:6 hold the trigger type (0 low level, 1 high level, 2 falling edge, 3 rising edge) and bits 2:0 hold the priority. All other bits read as 0.
- R3: Writing a bitmap to 0x120 enables each source whose bit is 1. Writing a bitmap to 0x124 disables each source whose bit is 1. Bits written as 0 change nothing. The enable bitmap reads back at 0x114, where 1 means enabled.
- R4: A source with a level trigger is pending exactly while its sampled input sits at the selected polarity. Inputs are sampled once on the clock.
- R5: A source with an edge trigger latches pending on the selected transition of its sampled input. The opposite transition does not set it.
- R6: Writing a bitmap to 0x128 sets the latched pending bit of each marked source. Writing a bitmap to 0x12C clears it.
- R7: Address 0x100 returns the sampled inputs, 0x104 returns the pending bits, and 0x108 returns the pending bits that are also enabled.
- R8: `irq_n` is low exactly when some enabled pending source may preempt. Among those sources the highest priority wins, and ties go to the lowest source number.
- R9: A read of 0x10C returns the winner's number times four. It acknowledges the winner by pushing it into service and clearing its latched pending bit. Address 0x110 returns the source in service, or 0 when nothing is in service.
- R10: While a source is in service, only an enabled pending source of strictly higher priority drives `irq_n` low. The in-service stack never overflows.
- R11: Any write to 0x130 pops one level of service and restores the previous source in service, if there is one.
- R12: A read of 0x10C when no source may preempt returns 0 and leaves the service state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Interrupt source inputs |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_rd | input | 1 | Read strobe, side effects at the clock edge |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from state |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Some properties are checked on every cycle: the reset state, the effect of the enable and disable commands on the mask, the tie between a low `irq_n` and a non-empty enabled-pending set, and stack growth on acknowledge and shrink on end-of-service, including the overflow bound. Other behaviours only the bench scenarios can show. These are the choice of winner under ties and differing priorities, the returned vector values, edge latching against level following, preemption only by strictly higher priority, restoring the previous level after a pop, and a spurious acknowledge that leaves service untouched.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_RISE = 2'd3
    } trig_e;

    // Register byte offsets; software decodes these, so they are fixed.
    localparam int unsigned OFS_RAW    = 'h100;
    localparam int unsigned OFS_ACTIVE = 'h104;
    localparam int unsigned OFS_STATUS = 'h108;
    localparam int unsigned OFS_VECTOR = 'h10C;
    localparam int unsigned OFS_CURSRC = 'h110;
    localparam int unsigned OFS_MASK   = 'h114;
    localparam int unsigned OFS_MEN    = 'h120;
    localparam int unsigned OFS_MDIS   = 'h124;
    localparam int unsigned OFS_SET    = 'h128;
    localparam int unsigned OFS_CLR    = 'h12C;
    localparam int unsigned OFS_EOS    = 'h130;

    localparam int unsigned TRIG_LSB = 6;
endpackage

// File: rtl/vpic_src_cell.sv
module vpic_src_cell
    import vpic_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  src_i,
    input  trig_e trig,
    input  logic  set_cmd,
    input  logic  clr_cmd,
    output logic  raw_o,
    output logic  pend_o
);
    typedef struct packed {
        logic smp;   // sampled input
        logic prv;   // previous sample
        logic lat;   // latched pending (edge or software)
    } cell_t;

    cell_t st_d, st_q;
    logic  edge_hit;
    logic  level_hit;

    always_comb begin
        unique case (trig)
            TRIG_FALL: edge_hit = st_q.prv & ~st_q.smp;
            TRIG_RISE: edge_hit = ~st_q.prv & st_q.smp;
            default:   edge_hit = 1'b0;
        endcase
        unique case (trig)
            TRIG_LOW:  level_hit = ~st_q.smp;
            TRIG_HIGH: level_hit = st_q.smp;
            default:   level_hit = 1'b0;
        endcase

        st_d     = st_q;
        st_d.smp = src_i;
        st_d.prv = st_q.smp;
        if (set_cmd || edge_hit) begin
            st_d.lat = 1'b1;
        end else if (clr_cmd) begin
            st_d.lat = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_o  = st_q.smp;
    assign pend_o = st_q.lat | level_hit;
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter #(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned IDX_W  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]   req,
    input  logic [PRIO_W-1:0] prio [NSRC],
    input  logic              floor_en,
    input  logic [PRIO_W-1:0] floor_prio,
    output logic              found,
    output logic [IDX_W-1:0]  win_idx,
    output logic [PRIO_W-1:0] win_prio
);
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < int'(NSRC); i++) begin
            if (req[i] && (!floor_en || prio[i] > floor_prio)
                       && (!found || prio[i] > win_prio)) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/vpic_stack.sv
module vpic_stack #(
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic [PRIO_W-1:0] push_prio,
    output logic              empty,
    output logic [IDX_W-1:0]  top_idx,
    output logic [PRIO_W-1:0] top_prio,
    output logic [CNT_W-1:0]  depth
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [CNT_W-1:0]              cnt;
        logic [DEPTH-1:0][IDX_W-1:0]   idx;
        logic [DEPTH-1:0][PRIO_W-1:0]  pri;
    } stk_t;

    stk_t st_d, st_q;
    logic [PTR_W-1:0] top_ptr;

    assign empty   = (st_q.cnt == '0);
    assign top_ptr = PTR_W'(st_q.cnt - CNT_W'(1));
    assign depth   = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (push && st_q.cnt < CNT_W'(DEPTH)) begin
            st_d.idx[PTR_W'(st_q.cnt)] = push_idx;
            st_d.pri[PTR_W'(st_q.cnt)] = push_prio;
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end else if (pop && !empty) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign top_idx  = empty ? '0 : st_q.idx[top_ptr];
    assign top_prio = empty ? '0 : st_q.pri[top_ptr];
endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned PRIO_W = 3,
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_n
);
    localparam int unsigned IDX_W = $clog2(NSRC);
    localparam int unsigned DEPTH = 1 << PRIO_W;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [NSRC-1:0]              mask;
        logic [NSRC-1:0][1:0]         trig;
        logic [NSRC-1:0][PRIO_W-1:0]  prio;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic              hit_ctl;
    logic [IDX_W-1:0]  ctl_sel;
    logic              ack, eos;
    logic [NSRC-1:0]   raw_v, pend_v, status, set_v, clr_v;
    logic [PRIO_W-1:0] prio_a [NSRC];
    logic              found;
    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] win_prio;
    logic              stk_empty;
    logic [IDX_W-1:0]  top_idx;
    logic [PRIO_W-1:0] top_prio;
    logic [CNT_W-1:0]  stk_depth;
    logic [NSRC-1:0]   mask_cur;

    function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned ofs);
        return a == ADDR_W'(ofs);
    endfunction

    assign ctl_sel = bus_addr[IDX_W+1:2];
    assign hit_ctl = (bus_addr < ADDR_W'(NSRC * 4)) && (bus_addr[1:0] == 2'b00);
    assign ack     = bus_rd && at(bus_addr, OFS_VECTOR) && found;
    assign eos     = bus_wr && at(bus_addr, OFS_EOS);
    assign set_v   = (bus_wr && at(bus_addr, OFS_SET)) ? bus_wdata[NSRC-1:0] : '0;
    assign clr_v   = ((bus_wr && at(bus_addr, OFS_CLR)) ? bus_wdata[NSRC-1:0] : '0)
                   | (ack ? (NSRC'(1) << win_idx) : '0);
    assign status  = pend_v & cfg_q.mask;
    assign mask_cur = cfg_q.mask;

    for (genvar i = 0; i < int'(NSRC); i++) begin : g_src
        vpic_src_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .src_i   (src_i[i]),
            .trig    (trig_e'(cfg_q.trig[i])),
            .set_cmd (set_v[i]),
            .clr_cmd (clr_v[i]),
            .raw_o   (raw_v[i]),
            .pend_o  (pend_v[i])
        );
        assign prio_a[i] = cfg_q.prio[i];
    end

    vpic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
        .req        (status),
        .prio       (prio_a),
        .floor_en   (!stk_empty),
        .floor_prio (top_prio),
        .found      (found),
        .win_idx    (win_idx),
        .win_prio   (win_prio)
    );

    vpic_stack #(.DEPTH(DEPTH), .IDX_W(IDX_W), .PRIO_W(PRIO_W), .CNT_W(CNT_W)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack),
        .pop       (eos),
        .push_idx  (win_idx),
        .push_prio (win_prio),
        .empty     (stk_empty),
        .top_idx   (top_idx),
        .top_prio  (top_prio),
        .depth     (stk_depth)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr) begin
            if (hit_ctl) begin
                cfg_d.trig[ctl_sel] = bus_wdata[TRIG_LSB+1:TRIG_LSB];
                cfg_d.prio[ctl_sel] = bus_wdata[PRIO_W-1:0];
            end
            if (at(bus_addr, OFS_MEN)) begin
                cfg_d.mask = cfg_q.mask | bus_wdata[NSRC-1:0];
            end
            if (at(bus_addr, OFS_MDIS)) begin
                cfg_d.mask = cfg_q.mask & ~bus_wdata[NSRC-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_ctl) begin
            bus_rdata = (32'(cfg_q.trig[ctl_sel]) << TRIG_LSB) | 32'(cfg_q.prio[ctl_sel]);
        end else if (at(bus_addr, OFS_RAW)) begin
            bus_rdata = 32'(raw_v);
        end else if (at(bus_addr, OFS_ACTIVE)) begin
            bus_rdata = 32'(pend_v);
        end else if (at(bus_addr, OFS_STATUS)) begin
            bus_rdata = 32'(status);
        end else if (at(bus_addr, OFS_VECTOR)) begin
            bus_rdata = found ? (32'(win_idx) << 2) : '0;
        end else if (at(bus_addr, OFS_CURSRC)) begin
            bus_rdata = 32'(top_idx);
        end else if (at(bus_addr, OFS_MASK)) begin
            bus_rdata = 32'(cfg_q.mask);
        end
    end

    assign irq_n = ~found;
endmodule

// File: rtl/vpic_chk.sv
module vpic_chk #(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NSRC-1:0]   mask,
    input logic [NSRC-1:0]   status,
    input logic              ack,
    input logic              eos,
    input logic [CNT_W-1:0]  depth
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq_n && mask == '0 && depth == '0));

    p_mask_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h120))
        |=> mask == ($past(mask) | $past(bus_wdata[NSRC-1:0])));

    p_mask_disable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h124))
        |=> mask == ($past(mask) & ~$past(bus_wdata[NSRC-1:0])));

    p_irq_needs_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> status != '0);

    p_idle_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == '0 && status != '0) |-> !irq_n);

    p_ack_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> depth == $past(depth) + CNT_W'(1));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> depth < CNT_W'(DEPTH));

    p_eos_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (eos && depth != '0) |=> depth == $past(depth) - CNT_W'(1));
endmodule

bind vpic_top vpic_chk #(
    .NSRC(NSRC), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_n     (irq_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mask      (mask_cur),
    .status    (status),
    .ack       (ack),
    .eos       (eos),
    .depth     (stk_depth)
);

// File: tb/sim_vpic_top.sv
`timescale 1ns/1ps
module sim_vpic_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        logic [9:0]  a;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    vpic_top u0 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr(wr), .bus_rd(rd),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_n(irq_n)
    );

    // Monitor: compares each read in the middle of its cycle.
    always @(negedge clk) begin
        if (rd && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (rdata !== it.exp) begin
                errors++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, rdata, it.exp);
            end
        end
    end

    task automatic wr_reg(input logic [9:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [9:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.exp = e; it.a = a; it.tag = tag;
        sb.push_back(it);
        rd = 1'b1; addr = a;
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        checks++;
        if (irq_n !== e) begin
            errors++;
            $display("FAIL %s irq_n actual=%b expected=%b", tag, irq_n, e);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk_irq(1'b1, "R1 irq idle");
        rd_reg(10'h114, 32'h0, "R1 mask cleared");
        rd_reg(10'h000, 32'h0, "R1 ctrl zero");
        rd_reg(10'h104, 32'hFFFF_FFFF, "R4 low level pending at reset");
        rd_reg(10'h108, 32'h0, "R7 masked status");

        // R2 control words: all high level, priority 0
        for (int i = 0; i < 32; i++) wr_reg(10'(i * 4), 32'h40);
        wr_reg(10'h014, 32'hFFFF_FFFF);
        rd_reg(10'h014, 32'h0000_00C7, "R2 ctrl field layout");
        wr_reg(10'h014, 32'h40);
        rd_reg(10'h014, 32'h0000_0040, "R2 ctrl readback");

        // R3 mask commands
        wr_reg(10'h120, 32'h0000_00F0);
        rd_reg(10'h114, 32'h0000_00F0, "R3 enable");
        wr_reg(10'h124, 32'h0000_0030);
        rd_reg(10'h114, 32'h0000_00C0, "R3 disable");
        wr_reg(10'h120, 32'h0);
        rd_reg(10'h114, 32'h0000_00C0, "R3 zero bits unchanged");
        wr_reg(10'h124, 32'hFFFF_FFFF);
        rd_reg(10'h114, 32'h0, "R3 disable all");

        // R4/R7 level high
        src[3] = 1'b1; idle(2);
        rd_reg(10'h100, 32'h8, "R7 raw");
        rd_reg(10'h104, 32'h8, "R4 high level active");
        rd_reg(10'h108, 32'h0, "R7 status masked");
        chk_irq(1'b1, "R8 masked no request");
        wr_reg(10'h120, 32'h8);
        chk_irq(1'b0, "R8 request when enabled");
        rd_reg(10'h108, 32'h8, "R7 status enabled");
        wr_reg(10'h00C, 32'h00);
        chk_irq(1'b1, "R4 low level with input high");
        rd_reg(10'h104, 32'h0, "R4 low level not active");
        wr_reg(10'h00C, 32'h40);
        chk_irq(1'b0, "R4 high level again");

        // R9 acknowledge, R11 end of service
        rd_reg(10'h10C, 32'd12, "R9 vector source 3");
        chk_irq(1'b1, "R10 same priority held off");
        rd_reg(10'h110, 32'd3, "R9 in-service source");
        rd_reg(10'h108, 32'h8, "R4 level stays pending after ack");
        wr_reg(10'h130, 32'h0);
        chk_irq(1'b0, "R11 request after end of service");
        rd_reg(10'h110, 32'd0, "R11 nothing in service");
        src[3] = 1'b0; idle(2);
        chk_irq(1'b1, "R4 level follows input");

        // R8 arbitration, R10 nesting
        wr_reg(10'h010, 32'h42);
        wr_reg(10'h014, 32'h45);
        wr_reg(10'h018, 32'h45);
        wr_reg(10'h120, 32'h70);
        src[6:4] = 3'b111; idle(2);
        rd_reg(10'h10C, 32'd20, "R8 tie to lowest index at top priority");
        chk_irq(1'b1, "R10 equal priority does not preempt");
        rd_reg(10'h110, 32'd5, "R9 in-service 5");
        wr_reg(10'h01C, 32'h47);
        wr_reg(10'h120, 32'h80);
        src[7] = 1'b1; idle(2);
        chk_irq(1'b0, "R10 higher priority preempts");
        rd_reg(10'h10C, 32'd28, "R9 vector source 7");
        rd_reg(10'h110, 32'd7, "R10 nested source");
        wr_reg(10'h130, 32'h0);
        rd_reg(10'h110, 32'd5, "R11 restores previous level");
        chk_irq(1'b0, "R10 source 7 still pending above 5");
        src[7] = 1'b0; idle(2);
        chk_irq(1'b1, "R10 lower or equal held off");
        wr_reg(10'h130, 32'h0);
        chk_irq(1'b0, "R11 empty stack serves again");
        rd_reg(10'h10C, 32'd20, "R8 winner after pop");
        wr_reg(10'h130, 32'h0);
        src[6:4] = 3'b000; idle(2);
        chk_irq(1'b1, "R4 all levels released");

        // R5 edges
        wr_reg(10'h028, 32'hC3);
        wr_reg(10'h120, 32'h400);
        src[10] = 1'b1; idle(1);
        src[10] = 1'b0; idle(3);
        rd_reg(10'h104, 32'h400, "R5 rising edge latched");
        chk_irq(1'b0, "R5 edge request");
        rd_reg(10'h10C, 32'd40, "R9 vector source 10");
        rd_reg(10'h104, 32'h0, "R9 ack clears edge latch");
        chk_irq(1'b1, "R9 no request after ack");
        wr_reg(10'h130, 32'h0);
        wr_reg(10'h02C, 32'h81);
        wr_reg(10'h120, 32'h800);
        src[11] = 1'b1; idle(3);
        rd_reg(10'h104, 32'h0, "R5 rising ignored on falling type");
        src[11] = 1'b0; idle(3);
        rd_reg(10'h104, 32'h800, "R5 falling edge latched");
        chk_irq(1'b0, "R5 falling request");

        // R6 software commands
        wr_reg(10'h12C, 32'h800);
        rd_reg(10'h104, 32'h0, "R6 clear command");
        chk_irq(1'b1, "R6 request dropped");
        wr_reg(10'h128, 32'h1000);
        rd_reg(10'h104, 32'h1000, "R6 set command");
        rd_reg(10'h108, 32'h0, "R7 set but masked");
        chk_irq(1'b1, "R8 masked set");
        wr_reg(10'h120, 32'h1000);
        chk_irq(1'b0, "R6 set request");
        rd_reg(10'h10C, 32'd48, "R9 vector source 12");
        rd_reg(10'h104, 32'h0, "R9 ack clears software pending");
        wr_reg(10'h130, 32'h0);

        // R12 spurious acknowledge
        chk_irq(1'b1, "R12 idle before spurious");
        rd_reg(10'h10C, 32'h0, "R12 spurious vector");
        rd_reg(10'h110, 32'h0, "R12 nothing in service");
        src[3] = 1'b1; idle(2);
        chk_irq(1'b0, "R12 priority 0 still served");
        src[3] = 1'b0; idle(2);
        chk_irq(1'b1, "R12 released");

        idle(2);
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule